// File: doc/BRIEF.md
# Pseudo-random switching load generator

This block fills a device with dense, irregular switching activity so that its logic fabric and its supply rails can be stressed under a load that resembles real traffic rather than a uniform toggle pattern. It is a ring of single-bit registers. Each register captures the exclusive-OR of the three registers that come before it in the ring, so every register comes with one small three-input function. This spreads the activity across both storage and combinational resources.

A free-running head register inverts itself on every clock edge. It is the only source of change in the ring, so it is what moves the ring out of the all-zero state that reset leaves behind. The first three ring positions take the head register in place of the neighbour they lack, and the rest of their inputs wrap around from the tail of the ring. One output bit, the exclusive-OR of the head register and the last ring register, depends on the whole structure. Routing it to a pin keeps synthesis from pruning the logic.

Top module: `churn_ring_top`

## Requirements
- R1: While `rst_n` is low, every register (the head and all ring cells) is zero, so `churn_o` reads 0. Driving `rst_n` low clears them at once, without waiting for a clock edge.
- R2: After reset is released, the head register inverts on every rising clock edge. It is 1 after the first edge.
- R3: For ring position i with 3 <= i < CELL_COUNT, the value after an edge is cell[i-3] ^ cell[i-2] ^ cell[i-1], using the values held before that edge.
- R4: Ring position 0 captures head ^ cell[CELL_COUNT-1] ^ cell[CELL_COUNT-2].
- R5: Ring position 1 captures head ^ cell[CELL_COUNT-1] ^ cell[0].
- R6: Ring position 2 captures head ^ cell[0] ^ cell[1].
- R7: `churn_o` is the exclusive-OR of the head register and cell[CELL_COUNT-1], with no register in between.
- R8: On the first cycle after reset release, `churn_o` reads 1. The head is 1 and the ring is still all zero.
- R9: The output sequence after a reset release is fully determined. Two runs that each start from reset produce the same bit stream.
- R10: CELL_COUNT must be at least 3. A smaller value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All registers update on its rising edge. |
| rst_n | input | 1 | Active-low asynchronous reset that clears every register |
| churn_o | output | 1 | Observation bit that keeps the ring from being pruned |

## Verification
A wrong tap deep in the ring can only be seen through one output bit. Its effect reaches the tail many cycles after the fault, and by then it is mixed with every other cell. The stimulus therefore runs the ring freely for several thousand cycles from reset. The bench advances a bit-exact model of the whole ring in step with the design and compares the single output every cycle, so any difference in the recurrence eventually shows up at the pin. Reset is also dropped between clock edges, at a moment when the model predicts the output is 1. This exposes the asynchronous clear immediately.

// File: rtl/churn_pkg.sv
package churn_pkg;
    // smallest ring for which every position has three distinct sources
    localparam int unsigned MIN_CELLS = 3;

    function automatic logic mix3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction
endpackage

// File: rtl/churn_head.sv
module churn_head (
    input  logic clk,
    input  logic rst_n,
    output logic head_q
);
    typedef struct packed {
        logic head;
    } head_state_t;

    head_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.head = ~st_q.head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_q = st_q.head;
endmodule

// File: rtl/churn_cells.sv
module churn_cells #(
    parameter int unsigned CELL_COUNT = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  head_q,
    output logic [CELL_COUNT-1:0] cells_q
);
    import churn_pkg::*;

    localparam int unsigned LAST = CELL_COUNT - 1;
    localparam int unsigned PREV = CELL_COUNT - 2;

    typedef struct packed {
        logic [CELL_COUNT-1:0] cells;
    } ring_state_t;

    ring_state_t st_d, st_q;

    logic [CELL_COUNT-1:0] src_a, src_b, src_c;

    // source selection: the first three positions wrap around through the head
    for (genvar i = 0; i < CELL_COUNT; i++) begin : g_src
        if (i == 0) begin : g_p0
            assign src_a[i] = head_q;
            assign src_b[i] = st_q.cells[LAST];
            assign src_c[i] = st_q.cells[PREV];
        end else if (i == 1) begin : g_p1
            assign src_a[i] = head_q;
            assign src_b[i] = st_q.cells[LAST];
            assign src_c[i] = st_q.cells[0];
        end else if (i == 2) begin : g_p2
            assign src_a[i] = head_q;
            assign src_b[i] = st_q.cells[0];
            assign src_c[i] = st_q.cells[1];
        end else begin : g_pn
            assign src_a[i] = st_q.cells[i-3];
            assign src_b[i] = st_q.cells[i-2];
            assign src_c[i] = st_q.cells[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CELL_COUNT; i++) begin
            st_d.cells[i] = mix3(src_a[i], src_b[i], src_c[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cells_q = st_q.cells;
endmodule

// File: rtl/churn_tap.sv
module churn_tap (
    input  logic head_q,
    input  logic tail_q,
    output logic tap_o
);
    always_comb begin
        tap_o = head_q ^ tail_q;
    end
endmodule

// File: rtl/churn_ring_top.sv
module churn_ring_top #(
    parameter int unsigned CELL_COUNT = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic churn_o
);
    import churn_pkg::*;

    // R10: reject rings too short to have three sources per position
    if (CELL_COUNT < MIN_CELLS) begin : g_len_check
        $error("churn_ring_top: CELL_COUNT must be at least 3 (R10)");
    end

    logic                  head_q;
    logic [CELL_COUNT-1:0] cells_q;

    churn_head u_head (
        .clk    (clk),
        .rst_n  (rst_n),
        .head_q (head_q)
    );

    churn_cells #(
        .CELL_COUNT (CELL_COUNT)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .head_q  (head_q),
        .cells_q (cells_q)
    );

    churn_tap u_tap (
        .head_q (head_q),
        .tail_q (cells_q[CELL_COUNT-1]),
        .tap_o  (churn_o)
    );
endmodule

// File: rtl/churn_ring_chk.sv
module churn_ring_chk #(
    parameter int unsigned CELL_COUNT = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  head_q,
    input logic [CELL_COUNT-1:0] cells_q
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (cells_q == '0 && head_q == 1'b0));

    assert_head_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> head_q != $past(head_q));

    assert_pos0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> cells_q[0] == ($past(head_q) ^ $past(cells_q[CELL_COUNT-1]) ^ $past(cells_q[CELL_COUNT-2])));

    assert_pos1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> cells_q[1] == ($past(head_q) ^ $past(cells_q[CELL_COUNT-1]) ^ $past(cells_q[0])));

    assert_pos2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> cells_q[2] == ($past(head_q) ^ $past(cells_q[0]) ^ $past(cells_q[1])));

    for (genvar i = 3; i < CELL_COUNT; i++) begin : g_body
        assert_body_R3: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> cells_q[i] == ($past(cells_q[i-3]) ^ $past(cells_q[i-2]) ^ $past(cells_q[i-1])));
    end
endmodule

bind churn_ring_top churn_ring_chk #(.CELL_COUNT(CELL_COUNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .head_q  (head_q),
    .cells_q (cells_q)
);

// File: tb/sim_churn_ring_top.sv
module sim_churn_ring_top;
    localparam int N = 32;
    localparam int REC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic churn_o;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;

    logic         m_head;
    logic [N-1:0] m_cells;
    logic [REC-1:0] rec_a, rec_b;

    always #10 clk = ~clk;

    churn_ring_top #(.CELL_COUNT(N)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .churn_o (churn_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: churn_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // bench model of one rising edge, taken from R2..R6
    task automatic model_step();
        logic [N-1:0] nx;
        nx[0] = m_head ^ m_cells[N-1] ^ m_cells[N-2];
        nx[1] = m_head ^ m_cells[N-1] ^ m_cells[0];
        nx[2] = m_head ^ m_cells[0] ^ m_cells[1];
        for (int i = 3; i < N; i++) nx[i] = m_cells[i-3] ^ m_cells[i-2] ^ m_cells[i-1];
        m_cells = nx;
        m_head  = ~m_head;
    endtask

    function automatic logic model_out();
        return m_head ^ m_cells[N-1];   // R7
    endfunction

    // holds reset for a few cycles, then releases it at a falling edge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_head = 1'b0;
        m_cells = '0;
        #1;
        check(churn_o, 1'b0, "R1 clear on assertion");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(churn_o, 1'b0, "R1 held in reset");
        end
        rst_n = 1'b1;
    endtask

    task automatic test_reset_state();
        do_reset();
    endtask

    task automatic test_first_cycle();
        do_reset();
        @(negedge clk);
        model_step();
        check(churn_o, 1'b1, "R8 first cycle after release");
    endtask

    task automatic test_free_run(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            model_step();
            check(churn_o, model_out(), "R2 R3 R4 R5 R6 R7 ring sequence");
        end
    endtask

    task automatic test_async_clear();
        int guard = 0;
        // run until the model predicts a 1 at the output
        do begin
            @(negedge clk);
            model_step();
            check(churn_o, model_out(), "R7 before async clear");
            guard++;
        end while (model_out() != 1'b1 && guard < 200);
        #3;
        rst_n = 1'b0;
        #2;
        check(churn_o, 1'b0, "R1 async clear between edges");
        m_head = 1'b0;
        m_cells = '0;
        @(negedge clk);
        check(churn_o, 1'b0, "R1 still clear");
        rst_n = 1'b1;
        test_free_run(300);
    endtask

    task automatic record(output logic [REC-1:0] bits);
        do_reset();
        for (int k = 0; k < REC; k++) begin
            @(negedge clk);
            model_step();
            bits[k] = churn_o;
        end
    endtask

    task automatic test_repeatable();
        record(rec_a);
        record(rec_b);
        vectors++;
        if (rec_a !== rec_b) begin
            misses++;
            $display("FAIL R9: second run %h expected %h", rec_b, rec_a);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        m_head = 1'b0;
        m_cells = '0;
        #1 rst_n = 1'b0;
        test_reset_state();
        test_first_cycle();
        test_free_run(2000);
        test_async_clear();
        test_repeatable();
        do_reset();
        test_free_run(500);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule